// File: doc/BRIEF.md
# Latency-Programmable Event Pattern Pulser

This block replays test events that were stored ahead of time in a 36-bit pattern memory. The memory is split into four equal regions, and a 2-bit buffer number selects one of them. Each stored event starts with a header word that gives the event's own output latency. Data words follow, and a trailer word ends the event. When a trigger accept arrives, the block latches the buffer number and starts a latency counter. It reads the header, then copies data words into an internal FIFO until it reaches the trailer. It releases the FIFO contents to the transmitter only after the counter reaches the header's latency.

A flag in any data word can ask for an idle gap. The gap uses one output slot with the transmit strobe low, so the output can follow the uneven timing of a real upstream source. The trailer payload is shown as the expected-decision word for the test. The memory is loaded through a plain write port while the block is idle. An accept that arrives while an event is in progress is dropped and recorded in a sticky overrun flag.

Top module: `event_pulser`

## Requirements
- R1: After reset, tx_enable_o, tx_strobe_o, busy_o, overrun_o and expect_valid_o are all low.
- R2: A memory word holds payload in bits 31:0 and flags in bits 35:32: bit 35 is header, bit 34 is trailer, bit 33 is gap, and bit 32 is reserved and ignored. Word address = {buffer number, index within region}, and the header sits at index 0. A write on the write port while the block is idle stores the word at that address.
- R3: The latency L is bits 15:0 of the header payload. Call the clock edge that samples an accepted accept_i edge 0. The first output slot is registered at edge max(4, L+1), and tx_enable_o is low before that edge.
- R4: Data words between the header and the trailer appear one per cycle, in memory order, in consecutive slots. In each slot tx_enable_o and tx_strobe_o are high and tx_data_o equals the word's payload.
- R5: A data word whose gap flag is set fills its slot with tx_enable_o high, tx_strobe_o low and tx_data_o equal to zero.
- R6: When busy_o falls after an event, expect_valid_o is high and expect_o holds the trailer payload. Both stay until the next accepted accept, which clears expect_valid_o.
- R7: busy_o is high from the accept edge until the FIFO has drained. An accept is taken only while busy_o is low.
- R8: An accept that arrives while busy_o is high sets overrun_o on the next edge. overrun_o stays set until reset, and the current event's output is unchanged.
- R9: A write request while busy_o is high is ignored, so the stored word keeps its old value.
- R10: If no trailer appears before the last index of a region, the last word is taken as the trailer. It is not output, and its payload becomes expect_o.
- R11: An event whose trailer directly follows its header produces no output slot and still reports its trailer payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Pattern memory write request |
| wr_addr_i | input | REGION_AW+2 | Write address {buffer, index} |
| wr_data_i | input | 36 | Word to store |
| accept_i | input | 1 | Trigger accept pulse |
| buf_i | input | 2 | Buffer number qualified by accept_i |
| tx_data_o | output | 32 | Transmit payload (zero outside strobed slots) |
| tx_enable_o | output | 1 | Output slot active (data or gap) |
| tx_strobe_o | output | 1 | Payload valid in this slot |
| expect_o | output | 32 | Trailer payload of the last event |
| expect_valid_o | output | 1 | expect_o holds the last event's trailer |
| busy_o | output | 1 | Event in progress |
| overrun_o | output | 1 | Sticky flag for a dropped accept |

## Verification
The first output slot of each event is due at edge max(4, L+1) after the edge that samples the accept. The following slots come one edge apart, one per data or gap word. An overrun shows one edge after the offending accept, and the expected-decision word is valid by the time busy falls. The bench numbers the edges from the accept. After every edge it compares all three transmit outputs with the slot pattern it builds from its own copy of the memory, sampling on the falling edge. The expect and overrun results are checked once busy has dropped.

// File: rtl/event_pulser_pkg.sv
package event_pulser_pkg;

    localparam int PAYLOAD_W = 32;
    localparam int WORD_W    = 36;
    localparam int HDR_BIT   = 35;
    localparam int TRL_BIT   = 34;
    localparam int GAP_BIT   = 33;
    localparam int RSV_BIT   = 32;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACCEPT = 3'd1,
        ST_HEADER = 3'd2,
        ST_COPY   = 3'd3,
        ST_WAIT   = 3'd4,
        ST_OUTPUT = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic                 gap;
        logic [PAYLOAD_W-1:0] payload;
    } fifo_word_t;

endpackage

// File: rtl/pulser_patmem.sv
module pulser_patmem
    import event_pulser_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [WORD_W-1:0] mem_q [WORDS];
    logic [WORD_W-1:0] rdata_q;

    // synchronous read, one cycle latency; storage carries no reset
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pulser_fifo.sv
module pulser_fifo
    import event_pulser_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  fifo_word_t wdata,
    input  logic       pop,
    output fifo_word_t rdata,
    output logic       empty,
    output logic       full
);
    localparam int DEPTH = 1 << PTR_W;

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W:0]   count;
    } fifo_regs_t;

    fifo_regs_t ptr_d, ptr_q;
    fifo_word_t store_q [DEPTH];

    logic do_push, do_pop;

    always_comb begin
        ptr_d   = ptr_q;
        do_push = push && (ptr_q.count != (PTR_W+1)'(DEPTH));
        do_pop  = pop && (ptr_q.count != '0);
        if (do_push) begin
            ptr_d.wr_ptr = ptr_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            ptr_d.rd_ptr = ptr_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   ptr_d.count = ptr_q.count + 1'b1;
            2'b01:   ptr_d.count = ptr_q.count - 1'b1;
            default: ptr_d.count = ptr_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store_q[ptr_q.wr_ptr] <= wdata;
        end
    end

    assign rdata = store_q[ptr_q.rd_ptr];
    assign empty = (ptr_q.count == '0);
    assign full  = (ptr_q.count == (PTR_W+1)'(DEPTH));

endmodule

// File: rtl/pulser_latcnt.sv
module pulser_latcnt #(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             load,
    input  logic [LAT_W-1:0] lat_i,
    output logic             reached_o
);
    typedef struct packed {
        logic [LAT_W-1:0] cnt;
        logic [LAT_W-1:0] lat;
        logic             armed;
    } lat_regs_t;

    lat_regs_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (start) begin
            lat_d.cnt   = '0;
            lat_d.armed = 1'b0;
        end else if (lat_q.cnt != '1) begin
            lat_d.cnt = lat_q.cnt + 1'b1;
        end
        if (load) begin
            lat_d.lat   = lat_i;
            lat_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign reached_o = lat_q.armed && (lat_q.cnt >= lat_q.lat);

endmodule

// File: rtl/pulser_seq.sv
module pulser_seq
    import event_pulser_pkg::*;
#(
    parameter int REGION_AW = 4,
    parameter int LAT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept_i,
    input  logic [1:0]             buf_i,
    output logic [REGION_AW+1:0]   mem_raddr_o,
    input  logic [WORD_W-1:0]      mem_rdata_i,
    output logic                   lat_start_o,
    output logic                   lat_load_o,
    output logic [LAT_W-1:0]       lat_value_o,
    input  logic                   lat_reached_i,
    output logic                   fifo_push_o,
    output fifo_word_t             fifo_wdata_o,
    output logic                   fifo_pop_o,
    input  fifo_word_t             fifo_rdata_i,
    input  logic                   fifo_empty_i,
    output logic [PAYLOAD_W-1:0]   tx_data_o,
    output logic                   tx_enable_o,
    output logic                   tx_strobe_o,
    output logic [PAYLOAD_W-1:0]   expect_o,
    output logic                   expect_valid_o,
    output logic                   busy_o,
    output logic                   overrun_o
);
    typedef struct packed {
        seq_state_e             state;
        logic [1:0]             bufn;
        logic [REGION_AW-1:0]   rd_idx;
        logic                   rd_last;
        logic [PAYLOAD_W-1:0]   expect_w;
        logic                   expect_valid;
        logic                   overrun;
        logic [PAYLOAD_W-1:0]   tx_data;
        logic                   tx_en;
        logic                   tx_strobe;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    logic draining;
    logic pop;
    logic unused_flags;

    assign unused_flags = ^{mem_rdata_i[HDR_BIT], mem_rdata_i[RSV_BIT]};

    always_comb begin
        s_d          = s_q;
        lat_start_o  = 1'b0;
        lat_load_o   = 1'b0;
        fifo_push_o  = 1'b0;
        fifo_wdata_o = '{gap: mem_rdata_i[GAP_BIT],
                         payload: mem_rdata_i[PAYLOAD_W-1:0]};

        // read pipeline: address issued now, word returns next cycle
        s_d.rd_idx  = s_q.rd_idx + 1'b1;
        s_d.rd_last = (s_q.rd_idx == '1);

        // output side: one FIFO word per slot once latency is met
        draining = (s_q.state == ST_COPY) || (s_q.state == ST_WAIT) ||
                   (s_q.state == ST_OUTPUT);
        pop = draining && lat_reached_i && !fifo_empty_i;
        s_d.tx_en     = pop;
        s_d.tx_strobe = pop && !fifo_rdata_i.gap;
        s_d.tx_data   = (pop && !fifo_rdata_i.gap) ? fifo_rdata_i.payload : '0;

        if (accept_i && (s_q.state != ST_IDLE)) begin
            s_d.overrun = 1'b1;
        end

        unique case (s_q.state)
            ST_IDLE: begin
                s_d.rd_idx = '0;
                if (accept_i) begin
                    s_d.bufn         = buf_i;
                    s_d.state        = ST_ACCEPT;
                    s_d.expect_valid = 1'b0;
                    s_d.expect_w     = '0;
                    lat_start_o      = 1'b1;
                end
            end
            ST_ACCEPT: begin
                s_d.state = ST_HEADER;
            end
            ST_HEADER: begin
                lat_load_o = 1'b1;
                s_d.state  = ST_COPY;
            end
            ST_COPY: begin
                if (mem_rdata_i[TRL_BIT] || s_q.rd_last) begin
                    s_d.expect_w     = mem_rdata_i[PAYLOAD_W-1:0];
                    s_d.expect_valid = 1'b1;
                    s_d.state        = ST_WAIT;
                end else begin
                    fifo_push_o = 1'b1;
                end
            end
            ST_WAIT: begin
                if (lat_reached_i) begin
                    s_d.state = ST_OUTPUT;
                end
            end
            ST_OUTPUT: begin
                if (fifo_empty_i) begin
                    s_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                s_d.state = ST_IDLE;
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_raddr_o    = {s_q.bufn, s_q.rd_idx};
    assign lat_value_o    = mem_rdata_i[LAT_W-1:0];
    assign fifo_pop_o     = pop;
    assign tx_data_o      = s_q.tx_data;
    assign tx_enable_o    = s_q.tx_en;
    assign tx_strobe_o    = s_q.tx_strobe;
    assign expect_o       = s_q.expect_w;
    assign expect_valid_o = s_q.expect_valid;
    assign busy_o         = (s_q.state != ST_IDLE);
    assign overrun_o      = s_q.overrun;

endmodule

// File: rtl/event_pulser.sv
module event_pulser
    import event_pulser_pkg::*;
#(
    parameter int REGION_AW = 4,
    parameter int LAT_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REGION_AW+1:0]  wr_addr_i,
    input  logic [35:0]           wr_data_i,
    input  logic                  accept_i,
    input  logic [1:0]            buf_i,
    output logic [31:0]           tx_data_o,
    output logic                  tx_enable_o,
    output logic                  tx_strobe_o,
    output logic [31:0]           expect_o,
    output logic                  expect_valid_o,
    output logic                  busy_o,
    output logic                  overrun_o
);
    localparam int MEM_AW = REGION_AW + 2;

    logic [MEM_AW-1:0] mem_raddr;
    logic [WORD_W-1:0] mem_rdata;
    logic              mem_we;
    logic              lat_start, lat_load, lat_reached;
    logic [LAT_W-1:0]  lat_value;
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    fifo_word_t        fifo_wdata, fifo_rdata;
    logic              busy;

    assign mem_we = wr_en_i && !busy;
    assign busy_o = busy;

    pulser_patmem #(.AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr_i),
        .wdata (wr_data_i),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    pulser_fifo #(.PTR_W(REGION_AW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    pulser_latcnt #(.LAT_W(LAT_W)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (lat_start),
        .load      (lat_load),
        .lat_i     (lat_value),
        .reached_o (lat_reached)
    );

    pulser_seq #(.REGION_AW(REGION_AW), .LAT_W(LAT_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept_i       (accept_i),
        .buf_i          (buf_i),
        .mem_raddr_o    (mem_raddr),
        .mem_rdata_i    (mem_rdata),
        .lat_start_o    (lat_start),
        .lat_load_o     (lat_load),
        .lat_value_o    (lat_value),
        .lat_reached_i  (lat_reached),
        .fifo_push_o    (fifo_push),
        .fifo_wdata_o   (fifo_wdata),
        .fifo_pop_o     (fifo_pop),
        .fifo_rdata_i   (fifo_rdata),
        .fifo_empty_i   (fifo_empty),
        .tx_data_o      (tx_data_o),
        .tx_enable_o    (tx_enable_o),
        .tx_strobe_o    (tx_strobe_o),
        .expect_o       (expect_o),
        .expect_valid_o (expect_valid_o),
        .busy_o         (busy),
        .overrun_o      (overrun_o)
    );

endmodule

// File: rtl/event_pulser_chk.sv
module event_pulser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        accept_i,
    input logic        busy_o,
    input logic        overrun_o,
    input logic        tx_enable_o,
    input logic        tx_strobe_o,
    input logic [31:0] tx_data_o,
    input logic        fifo_full,
    input logic        fifo_push,
    input logic        lat_reached
);
    // R4: payload is only strobed inside an active slot
    a_r4_strobe_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe_o |-> tx_enable_o);

    // R5: a gap slot carries a zero payload
    a_r5_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable_o && !tx_strobe_o) |-> (tx_data_o == 32'd0));

    // R3: a slot opens only after the latency counter reported reached
    a_r3_latency_gate: assert property (@(posedge clk) disable iff (!rst_n)
        tx_enable_o |-> $past(lat_reached));

    // R7: output only while an event is in progress; the FIFO never overfills
    a_r7_out_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_enable_o |-> busy_o);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    // R8: accept during busy sets a flag that never clears
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && busy_o) |=> overrun_o);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

endmodule

bind event_pulser event_pulser_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_i),
    .busy_o      (busy_o),
    .overrun_o   (overrun_o),
    .tx_enable_o (tx_enable_o),
    .tx_strobe_o (tx_strobe_o),
    .tx_data_o   (tx_data_o),
    .fifo_full   (fifo_full),
    .fifo_push   (fifo_push),
    .lat_reached (lat_reached)
);

// File: tb/event_pulser_tb_top.sv
module event_pulser_tb_top;

    localparam int RA    = 4;
    localparam int RSIZE = 1 << RA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [5:0]  wr_addr_i = '0;
    logic [35:0] wr_data_i = '0;
    logic        accept_i = 1'b0;
    logic [1:0]  buf_i = '0;
    logic [31:0] tx_data_o;
    logic        tx_enable_o, tx_strobe_o;
    logic [31:0] expect_o;
    logic        expect_valid_o, busy_o, overrun_o;

    int compared = 0;
    int mismatched = 0;

    logic [35:0] shadow [64];

    always #10 clk = ~clk;

    event_pulser #(.REGION_AW(RA), .LAT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .accept_i(accept_i), .buf_i(buf_i),
        .tx_data_o(tx_data_o), .tx_enable_o(tx_enable_o), .tx_strobe_o(tx_strobe_o),
        .expect_o(expect_o), .expect_valid_o(expect_valid_o), .busy_o(busy_o),
        .overrun_o(overrun_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int first_slot(input int lat);
        return (lat + 1 > 4) ? lat + 1 : 4;
    endfunction

    // R2: plain write through the port while idle; called at a falling edge
    task automatic wr(input logic [1:0] b, input int idx, input logic [35:0] d);
        wr_en_i   = 1'b1;
        wr_addr_i = {b, 4'(idx)};
        wr_data_i = d;
        @(negedge clk);
        wr_en_i   = 1'b0;
        shadow[{b, 4'(idx)}] = d;
    endtask

    task automatic build_event(input logic [1:0] b, input int lat, input int n,
                               input int gapmask, input bit no_trl);
        wr(b, 0, {4'b1000, 16'($urandom), 16'(lat)});
        for (int j = 0; j < n; j++) begin
            wr(b, j + 1, {2'b00, 1'((gapmask >> j) & 1), 1'($urandom), 32'($urandom)});
        end
        if (!no_trl) begin
            wr(b, n + 1, {4'b0100, 32'($urandom)});
        end
    endtask

    task automatic run_event(input logic [1:0] b, input int inj_acc_k,
                             input int inj_wr_k, input logic [5:0] inj_addr,
                             input logic [35:0] inj_data);
        int lat, n, s, tidx, last_k;
        logic [31:0] pay [RSIZE];
        bit gap [RSIZE];
        logic [31:0] trl;
        bit e_en, e_st;
        logic [31:0] e_dt;
        lat  = int'(shadow[{b, 4'd0}][15:0]);
        n    = 0;
        tidx = 1;
        while (!(shadow[{b, 4'(tidx)}][34] || tidx == RSIZE - 1)) begin
            pay[n] = shadow[{b, 4'(tidx)}][31:0];
            gap[n] = shadow[{b, 4'(tidx)}][33];
            n++;
            tidx++;
        end
        trl    = shadow[{b, 4'(tidx)}][31:0];
        s      = first_slot(lat);
        last_k = s + n + 3;

        for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
        accept_i = 1'b1;
        buf_i    = b;
        @(negedge clk);
        accept_i = 1'b0;
        for (int k = 1; k <= last_k; k++) begin
            @(negedge clk);
            if (k == 1) check("R7 busy after accept", 32'(busy_o), 32'd1);
            e_en = (k >= s) && (k < s + n);
            e_st = e_en && !gap[k - s];
            e_dt = e_st ? pay[k - s] : 32'd0;
            check("R3/R4/R5/R11 tx_enable", 32'(tx_enable_o), 32'(e_en));
            check("R4/R5 tx_strobe", 32'(tx_strobe_o), 32'(e_st));
            check("R4/R5 tx_data", tx_data_o, e_dt);
            accept_i = (k == inj_acc_k);
            if (k == inj_wr_k) begin
                wr_en_i   = 1'b1;
                wr_addr_i = inj_addr;
                wr_data_i = inj_data;
            end else begin
                wr_en_i = 1'b0;
            end
        end
        accept_i = 1'b0;
        wr_en_i  = 1'b0;
        for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
        check("R7 busy clears", 32'(busy_o), 32'd0);
        check("R6/R10/R11 expect_valid", 32'(expect_valid_o), 32'd1);
        check("R6/R10/R11 expect", expect_o, trl);
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 tx_enable", 32'(tx_enable_o), 32'd0);
        check("R1 tx_strobe", 32'(tx_strobe_o), 32'd0);
        check("R1 busy", 32'(busy_o), 32'd0);
        check("R1 overrun", 32'(overrun_o), 32'd0);
        check("R1 expect_valid", 32'(expect_valid_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: zero latency, plain data
        build_event(2'd0, 0, 3, 0, 1'b0);
        run_event(2'd0, -1, -1, '0, '0);
        // R5: long latency with a gap word
        build_event(2'd1, 30, 4, 4'b0010, 1'b0);
        run_event(2'd1, -1, -1, '0, '0);
        // R11: empty event
        build_event(2'd2, 5, 0, 0, 1'b0);
        run_event(2'd2, -1, -1, '0, '0);
        // R10: no trailer in the whole region
        build_event(2'd3, 2, RSIZE - 1, 32'h0000_2004, 1'b1);
        run_event(2'd3, -1, -1, '0, '0);
        // latency exactly at the boundary of the fill time
        build_event(2'd0, 3, 5, 0, 1'b0);
        run_event(2'd0, -1, -1, '0, '0);

        // random events
        for (int r = 0; r < 24; r++) begin
            logic [1:0] b;
            b = 2'($urandom);
            build_event(b, int'($urandom % 21), int'($urandom % 7),
                        int'($urandom & 32'h3f) & int'($urandom & 32'h3f), 1'b0);
            run_event(b, -1, -1, '0, '0);
        end
        check("R8 no overrun yet", 32'(overrun_o), 32'd0);

        // R9: write during busy to another region is ignored
        build_event(2'd0, 6, 4, 0, 1'b0);
        build_event(2'd1, 1, 3, 0, 1'b0);
        run_event(2'd0, -1, 3, {2'd1, 4'd1}, 36'h0_DEAD_BEEF);
        run_event(2'd1, -1, -1, '0, '0);

        // R8: accept during busy is dropped and flagged
        build_event(2'd2, 8, 3, 4'b0100, 1'b0);
        run_event(2'd2, 2, -1, '0, '0);
        check("R8 overrun set", 32'(overrun_o), 32'd1);
        run_event(2'd0, -1, -1, '0, '0);
        check("R8 overrun sticky", 32'(overrun_o), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired: actual=hang expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule